// File: doc/BRIEF.md
# Single-Pin Trim Configuration Controller

This block runs the configuration protocol of a trimmable oscillator that is set up through one serial pin. An edge decoder in front of it turns the pin waveform into a one-cycle bit strobe with a bit value. A separate timer raises a timeout pulse whenever the pin timing is broken. At power-up the block waits for the nonvolatile settings to be fetched and copies them into three 8-bit trim words. It then sits in the normal state, where it watches for one of two 6-bit entry codes.

The first entry code opens a register programming mode. In that mode, 10-bit frames either overwrite one trim word or, when the prefix is `11`, jump to another state. A written word drives the trim outputs on the next clock, before anything is made permanent. Two jump payloads start a nonvolatile write, one of them also sealing the device. The write itself is only a request/acknowledge pair at the port. The second entry code starts a read-back that shifts the three words out, prefix first, over 30 strobes.

Top module: `trim_cfg_ctrl`

## Requirements
- R1: After reset, `mode_state` is 0 and `out_en` is 0, and strobes are ignored, until `boot_done` is seen. On that clock, word 0 takes `boot_data[7:0]`, word 1 takes `[15:8]` and word 2 takes `[23:16]`, and `mode_state` becomes 1 (normal).
- R2: In normal state, bits are gathered first bit in the most significant position. Six bits equal to 001100 give `mode_state` 2 (programming). Six bits equal to 111011 give 5 (read-back). Any other six bits are dropped and the state stays 1.
- R3: In state 2, a 10-bit frame with prefix (first two bits) 00, 10 or 01 writes its last 8 bits to word 0, 1 or 2 respectively. The new value appears on `trim_words` one clock after the 10th strobe, and the state stays 2.
- R4: In state 2, a frame with prefix 11 is a jump. Payload FF goes to state 1, payload F0 goes to state 3 (permanent write, unsealed), and payload 55 goes to state 4 (permanent write, sealed). Any other payload goes to state 1.
- R5: In state 3 or 4, the frame 11 0000 0000, like any other complete 10-bit frame, returns the block to state 1.
- R6: In state 5, strobe k (k = 0 to 29) puts bit k of the stream {00, word0, 10, word1, 01, word2}, most significant bit first, on `rb_data` one clock later. The incoming bit value is ignored and the trim words stay unchanged. The 30th strobe returns the block to state 1.
- R7: A timeout pulse discards any partly gathered bits in every state, including a strobe in the same clock. In state 5 it returns the block to state 1; in states 1 to 4 the state is kept.
- R8: On entering state 3 or 4 with no seal recorded, `prog_req` rises one clock after the 10th strobe, with `prog_lock` 0 for state 3 and 1 for state 4. It stays high until a clock with `prog_ack` high. A new entry in the same clock as an acknowledge of an older request leaves a fresh request raised.
- R9: Once a request with `prog_lock` = 1 has been acknowledged, later entries into state 3 or 4 still change state but raise no request.
- R10: `out_en` follows `en_pin` one clock later in state 1. It is 1 in states 2 to 5 whatever `en_pin` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-cycle strobe marking a decoded serial bit |
| bit_val | input | 1 | Value of the strobed bit |
| timeout_pulse | input | 1 | Serial timing violation |
| en_pin | input | 1 | Device enable pin level |
| boot_data | input | 24 | Settings fetched from nonvolatile storage, word 0 in the low byte |
| boot_done | input | 1 | Nonvolatile fetch complete |
| prog_ack | input | 1 | Nonvolatile write accepted |
| trim_words | output | 24 | Live trim words, word 0 in the low byte |
| out_en | output | 1 | Output driver enable |
| prog_req | output | 1 | Nonvolatile write request |
| prog_lock | output | 1 | Request also seals the device |
| rb_data | output | 1 | Read-back serial bit |
| mode_state | output | 3 | Protocol state: 0 boot, 1 normal, 2 programming, 3 unsealed write, 4 sealed write, 5 read-back |

## Verification
Two events can meet in one clock: a frame that enters the sealed write state, and the acknowledge of an earlier unsealed request that is still pending. The bench leaves a state-3 request unacknowledged, returns through normal and programming mode, and raises `prog_ack` exactly in the clock of the 10th strobe of the 11 0101 0101 jump. It then expects `prog_req` still high with `prog_lock` = 1. Since the acknowledged request was unsealed, the device is not sealed yet; only a second acknowledge seals it, and a later state-3 entry must then raise no request.

// File: rtl/trim_cfg_pkg.sv
package trim_cfg_pkg;
  localparam int WORD_W    = 8;
  localparam int PFX_W     = 2;
  localparam int NUM_WORDS = 3;
  localparam int ENTRY_W   = 6;
  localparam int FRAME_W   = PFX_W + WORD_W;

  typedef enum logic [2:0] {
    ST_BOOT      = 3'd0,
    ST_IDLE      = 3'd1,
    ST_REG       = 3'd2,
    ST_PROG_OPEN = 3'd3,
    ST_PROG_SEAL = 3'd4,
    ST_READ      = 3'd5
  } cfg_state_e;

  localparam logic [ENTRY_W-1:0] CODE_REG  = 6'b001100;
  localparam logic [ENTRY_W-1:0] CODE_READ = 6'b111011;

  localparam logic [PFX_W-1:0]  PFX_JUMP      = 2'b11;
  localparam logic [WORD_W-1:0] JMP_LEAVE     = 8'hFF;
  localparam logic [WORD_W-1:0] JMP_PROG_OPEN = 8'hF0;
  localparam logic [WORD_W-1:0] JMP_PROG_SEAL = 8'h55;

  // prefix that addresses trim word idx
  function automatic logic [PFX_W-1:0] word_prefix(input int idx);
    case (idx)
      0:       word_prefix = 2'b00;
      1:       word_prefix = 2'b10;
      2:       word_prefix = 2'b01;
      default: word_prefix = 2'b11;
    endcase
  endfunction
endpackage

// File: rtl/trim_bit_collector.sv
module trim_bit_collector #(
  parameter int DEPTH = 10,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             stb,
  input  logic             val,
  output logic [DEPTH-2:0] bits_q,
  output logic [CW-1:0]    cnt_q
);
  // Holds all but the newest bit; the caller appends the live bit itself.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      bits_q <= '0;
      cnt_q  <= '0;
    end else if (stb) begin
      bits_q <= {bits_q[DEPTH-3:0], val};
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  AST_COLLECT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(DEPTH)); // R2
endmodule

// File: rtl/trim_word_bank.sv
module trim_word_bank #(
  parameter int WORD_W    = 8,
  parameter int NUM_WORDS = 3,
  localparam int IDXW = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int BUS_W = WORD_W * NUM_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BUS_W-1:0]  load_data,
  input  logic              wr_en,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  output logic [BUS_W-1:0]  words_q
);
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        words_q[g*WORD_W +: WORD_W] <= '0;
      else if (load)
        words_q[g*WORD_W +: WORD_W] <= load_data[g*WORD_W +: WORD_W];
      else if (wr_en && wr_idx == IDXW'(g))
        words_q[g*WORD_W +: WORD_W] <= wr_data;
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !load && wr_idx == '0) |=> words_q[WORD_W-1:0] == $past(wr_data)); // R3
endmodule

// File: rtl/trim_readout.sv
module trim_readout
  import trim_cfg_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int NUM_WORDS = 3,
  localparam int SLOT_W  = WORD_W + PFX_W,
  localparam int RB_BITS = SLOT_W * NUM_WORDS,
  localparam int IW      = $clog2(RB_BITS),
  localparam int BUS_W   = WORD_W * NUM_WORDS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stb,
  input  logic [BUS_W-1:0] words,
  output logic             bit_q,
  output logic             last
);
  localparam logic [IW-1:0] TOP_IDX = IW'(RB_BITS - 1);

  logic [RB_BITS-1:0] stream;
  logic [IW-1:0]      idx_q;

  // word 0 occupies the most significant slot so it leaves first
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_slot
    assign stream[(NUM_WORDS-1-g)*SLOT_W +: SLOT_W] =
      {word_prefix(g), words[g*WORD_W +: WORD_W]};
  end

  assign last = stb && (idx_q == TOP_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      bit_q <= 1'b0;
    end else if (start) begin
      idx_q <= '0;
    end else if (stb) begin
      bit_q <= stream[TOP_IDX - idx_q];
      idx_q <= last ? '0 : idx_q + 1'b1;
    end
  end

  AST_RB_RANGE: assert property (@(posedge clk) disable iff (rst)
    idx_q <= TOP_IDX); // R6
endmodule

// File: rtl/trim_cfg_ctrl.sv
module trim_cfg_ctrl
  import trim_cfg_pkg::*;
#(
  parameter int WORD_W    = trim_cfg_pkg::WORD_W,
  parameter int NUM_WORDS = trim_cfg_pkg::NUM_WORDS,
  localparam int BUS_W  = WORD_W * NUM_WORDS,
  localparam int FRM_W  = PFX_W + WORD_W,
  localparam int CW     = $clog2(FRM_W + 1),
  localparam int IDXW   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_stb,
  input  logic             bit_val,
  input  logic             timeout_pulse,
  input  logic             en_pin,
  input  logic [BUS_W-1:0] boot_data,
  input  logic             boot_done,
  input  logic             prog_ack,
  output logic [BUS_W-1:0] trim_words,
  output logic             out_en,
  output logic             prog_req,
  output logic             prog_lock,
  output logic             rb_data,
  output logic [2:0]       mode_state
);
  cfg_state_e st_q, st_d;

  logic [FRM_W-2:0]  col_bits;
  logic [CW-1:0]     col_cnt;
  logic              col_stb, col_clr;
  logic [FRM_W-1:0]  shifted;
  logic              got_entry, got_frame;
  logic [PFX_W-1:0]  frame_pfx;
  logic [WORD_W-1:0] frame_pay;
  logic              wr_en;
  logic [IDXW-1:0]   wr_idx;
  logic              rb_stb, rb_last, rb_start;
  logic              enter_prog, boot_load;
  logic              sealed_q;

  // ---------------- bit gathering ----------------
  assign col_stb = bit_stb && !timeout_pulse &&
                   (st_q == ST_IDLE || st_q == ST_REG ||
                    st_q == ST_PROG_OPEN || st_q == ST_PROG_SEAL);
  assign shifted   = {col_bits, bit_val};
  assign got_entry = col_stb && (st_q == ST_IDLE) && (col_cnt == CW'(ENTRY_W - 1));
  assign got_frame = col_stb && (st_q != ST_IDLE) && (col_cnt == CW'(FRM_W - 1));
  assign frame_pfx = shifted[FRM_W-1 -: PFX_W];
  assign frame_pay = shifted[WORD_W-1:0];

  trim_bit_collector #(.DEPTH(FRM_W)) u_collect (
    .clk(clk), .rst(rst), .clr(col_clr), .stb(col_stb), .val(bit_val),
    .bits_q(col_bits), .cnt_q(col_cnt)
  );

  // ---------------- protocol state ----------------
  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_BOOT: if (boot_done) st_d = ST_IDLE;
      ST_IDLE: if (got_entry) begin
        if (shifted[ENTRY_W-1:0] == CODE_REG)       st_d = ST_REG;
        else if (shifted[ENTRY_W-1:0] == CODE_READ) st_d = ST_READ;
      end
      ST_REG: if (got_frame && frame_pfx == PFX_JUMP) begin
        case (frame_pay)
          JMP_PROG_OPEN: st_d = ST_PROG_OPEN;
          JMP_PROG_SEAL: st_d = ST_PROG_SEAL;
          default:       st_d = ST_IDLE;
        endcase
      end
      ST_PROG_OPEN, ST_PROG_SEAL: if (got_frame) st_d = ST_IDLE;
      ST_READ: if (timeout_pulse || rb_last) st_d = ST_IDLE;
      default: st_d = ST_BOOT;
    endcase
  end

  assign col_clr = timeout_pulse || (st_d != st_q) || got_entry || got_frame;

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_BOOT;
    else     st_q <= st_d;
  end

  assign mode_state = st_q;

  // ---------------- trim words ----------------
  assign boot_load = (st_q == ST_BOOT) && boot_done;
  assign wr_en     = got_frame && (st_q == ST_REG) && (frame_pfx != PFX_JUMP);

  always_comb begin
    wr_idx = '0;
    for (int g = 0; g < NUM_WORDS; g++)
      if (frame_pfx == word_prefix(g)) wr_idx = IDXW'(g);
  end

  trim_word_bank #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_bank (
    .clk(clk), .rst(rst), .load(boot_load), .load_data(boot_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(frame_pay), .words_q(trim_words)
  );

  // ---------------- read-back ----------------
  assign rb_stb   = bit_stb && !timeout_pulse && (st_q == ST_READ);
  assign rb_start = (st_d == ST_READ) && (st_q != ST_READ);

  trim_readout #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_readout (
    .clk(clk), .rst(rst), .start(rb_start), .stb(rb_stb), .words(trim_words),
    .bit_q(rb_data), .last(rb_last)
  );

  // ---------------- nonvolatile request and output enable ----------------
  assign enter_prog = (st_q == ST_REG) &&
                      (st_d == ST_PROG_OPEN || st_d == ST_PROG_SEAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_req  <= 1'b0;
      prog_lock <= 1'b0;
      sealed_q  <= 1'b0;
      out_en    <= 1'b0;
    end else begin
      if (enter_prog && !sealed_q) begin
        prog_req  <= 1'b1;
        prog_lock <= (st_d == ST_PROG_SEAL);
      end else if (prog_req && prog_ack) begin
        prog_req <= 1'b0;
      end
      if (prog_req && prog_ack && prog_lock) sealed_q <= 1'b1;
      case (st_q)
        ST_BOOT: out_en <= 1'b0;
        ST_IDLE: out_en <= en_pin;
        default: out_en <= 1'b1;
      endcase
    end
  end

  // ---------------- assertions ----------------
  AST_BOOT_EXIT: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_BOOT && boot_done) |=> (mode_state == 3'd1)); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (prog_req && !prog_ack) |=> prog_req); // R8
  AST_REQ_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    $rose(prog_req) |-> ((mode_state == 3'd3 && !prog_lock) ||
                         (mode_state == 3'd4 && prog_lock))); // R8
  AST_SEAL_FINAL: assert property (@(posedge clk) disable iff (rst)
    sealed_q |=> !$rose(prog_req)); // R9
  AST_BUSY_OUTEN: assert property (@(posedge clk) disable iff (rst)
    (mode_state >= 3'd2) |=> out_en); // R10
  AST_READ_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (mode_state == 3'd5) |=> $stable(trim_words)); // R6
  AST_TIMEOUT_READ: assert property (@(posedge clk) disable iff (rst)
    (mode_state == 3'd5 && timeout_pulse) |=> (mode_state == 3'd1)); // R7
endmodule

// File: tb/trim_cfg_ctrl_test.sv
module trim_cfg_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_stb = 1'b0, bit_val = 1'b0, timeout_pulse = 1'b0;
  logic en_pin = 1'b1, boot_done = 1'b0, prog_ack = 1'b0;
  logic [23:0] boot_data = 24'h0;
  logic [23:0] trim_words;
  logic out_en, prog_req, prog_lock, rb_data;
  logic [2:0] mode_state;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trim_cfg_ctrl uut (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_val(bit_val),
    .timeout_pulse(timeout_pulse), .en_pin(en_pin), .boot_data(boot_data),
    .boot_done(boot_done), .prog_ack(prog_ack), .trim_words(trim_words),
    .out_en(out_en), .prog_req(prog_req), .prog_lock(prog_lock),
    .rb_data(rb_data), .mode_state(mode_state)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int   m_state;
  logic [7:0] m_words [3];
  bit   q[$];
  bit   rq[$];
  bit   m_req, m_lock, m_sealed, m_oe, m_rb;

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_words[0] = 0; m_words[1] = 0; m_words[2] = 0;
      q.delete(); rq.delete();
      m_req = 0; m_lock = 0; m_sealed = 0; m_oe = 0; m_rb = 0;
    end else begin
      int ns;
      int v;
      bit oe_n, ackd, old_lock;
      ns = m_state;
      oe_n = (m_state == 0) ? 1'b0 : (m_state == 1) ? en_pin : 1'b1;
      if (m_state == 0) begin
        if (boot_done) begin
          m_words[0] = boot_data[7:0]; m_words[1] = boot_data[15:8];
          m_words[2] = boot_data[23:16]; ns = 1;
        end
      end else if (timeout_pulse) begin
        q.delete();
        if (m_state == 5) ns = 1;
      end else if (bit_stb) begin
        if (m_state == 5) begin
          m_rb = rq.pop_front();
          if (rq.size() == 0) ns = 1;
        end else begin
          q.push_back(bit_val);
          if ((m_state == 1 && q.size() == 6) || (m_state != 1 && q.size() == 10)) begin
            v = 0;
            foreach (q[i]) v = (v << 1) | int'(q[i]);
            q.delete();
            if (m_state == 1) begin
              if (v == 'b001100) ns = 2;
              else if (v == 'b111011) ns = 5;
            end else if (m_state == 2) begin
              case (v >> 8)
                0: m_words[0] = v[7:0];
                2: m_words[1] = v[7:0];
                1: m_words[2] = v[7:0];
                default: ns = ((v & 'hFF) == 'hF0) ? 3 : ((v & 'hFF) == 'h55) ? 4 : 1;
              endcase
            end else ns = 1;
          end
        end
      end
      if (ns != m_state) q.delete();
      if (ns == 5 && m_state != 5) begin
        rq.delete();
        for (int w = 0; w < 3; w++) begin
          rq.push_back(w == 1); rq.push_back(w == 2);
          for (int b = 7; b >= 0; b--) rq.push_back(m_words[w][b]);
        end
      end
      ackd = m_req && prog_ack;
      old_lock = m_lock;
      if (m_state == 2 && (ns == 3 || ns == 4) && !m_sealed) begin
        m_req = 1; m_lock = (ns == 4);
      end else if (ackd) m_req = 0;
      if (ackd && old_lock) m_sealed = 1;
      m_state = ns;
      m_oe = oe_n;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2", "model mode_state", 32'(mode_state), 32'(m_state));
      chk("R3", "model trim_words", 32'(trim_words), {8'h0, m_words[2], m_words[1], m_words[0]});
      chk("R8", "model prog_req", 32'(prog_req), 32'(m_req));
      chk("R8", "model prog_lock", 32'(prog_lock), 32'(m_lock));
      chk("R10", "model out_en", 32'(out_en), 32'(m_oe));
      chk("R6", "model rb_data", 32'(rb_data), 32'(m_rb));
    end
  end

  // ---------------- stimulus helpers (called at a falling edge) ----------------
  task automatic send_bit(input logic b);
    bit_stb = 1'b1; bit_val = b;
    @(negedge clk);
    bit_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_bits(input logic [9:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic pulse_timeout();
    timeout_pulse = 1'b1;
    @(negedge clk);
    timeout_pulse = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [29:0] exp_rb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: boot wait
    chk("R1", "boot state", 32'(mode_state), 0);
    chk("R1", "boot out_en", 32'(out_en), 0);
    send_bit(1'b1);
    chk("R1", "strobe ignored in boot", 32'(mode_state), 0);
    boot_data = 24'hC35A17; boot_done = 1'b1;
    @(negedge clk);
    boot_done = 1'b0;
    chk("R1", "boot load", 32'(trim_words), 32'hC35A17);
    chk("R1", "boot to idle", 32'(mode_state), 1);

    // R10: enable follows pin in normal state
    en_pin = 1'b0; @(negedge clk); @(negedge clk);
    chk("R10", "idle enable low", 32'(out_en), 0);
    en_pin = 1'b1; @(negedge clk); @(negedge clk);
    chk("R10", "idle enable high", 32'(out_en), 1);

    // R2: wrong entry code
    send_bits(10'b001101, 6);
    chk("R2", "bad entry stays idle", 32'(mode_state), 1);

    // R7: timeout discards partial entry, then R2: valid entry
    send_bits(10'b001, 3);
    pulse_timeout();
    send_bits(10'b001100, 6);
    chk("R7", "timeout realigns entry", 32'(mode_state), 2);

    // R10: enable ignored while programming
    en_pin = 1'b0; @(negedge clk); @(negedge clk);
    chk("R10", "enable ignored state 2", 32'(out_en), 1);

    // R3: word writes
    send_bits(10'b10_1010_0101, 10);
    chk("R3", "write word1", 32'(trim_words), 32'hC3A517);
    chk("R3", "stay programming", 32'(mode_state), 2);
    send_bits(10'b01_0011_1100, 10);
    send_bits(10'b00_1110_0001, 10);
    chk("R3", "write word2 and word0", 32'(trim_words), 32'h3CA5E1);

    // R4: leave jump
    send_bits(10'b11_1111_1111, 10);
    chk("R4", "jump FF to idle", 32'(mode_state), 1);
    en_pin = 1'b1;

    // R8: unsealed write request
    send_bits(10'b001100, 6);
    send_bits(10'b11_1111_0000, 10);
    chk("R4", "jump F0 to state 3", 32'(mode_state), 3);
    chk("R8", "request raised", 32'(prog_req), 1);
    chk("R8", "request unsealed", 32'(prog_lock), 0);
    repeat (4) @(negedge clk);
    chk("R8", "request held", 32'(prog_req), 1);
    // R5: exit frame
    send_bits(10'b11_0000_0000, 10);
    chk("R5", "exit state 3", 32'(mode_state), 1);

    // R8: new sealed entry in same cycle as ack of old request
    send_bits(10'b001100, 6);
    send_bits(10'b11_0101_0101 >> 1, 9);
    prog_ack = 1'b1; bit_stb = 1'b1; bit_val = 1'b1;
    @(negedge clk);
    prog_ack = 1'b0; bit_stb = 1'b0;
    chk("R4", "jump 55 to state 4", 32'(mode_state), 4);
    chk("R8", "fresh request survives ack", 32'(prog_req), 1);
    chk("R8", "fresh request sealed", 32'(prog_lock), 1);
    prog_ack = 1'b1; @(negedge clk); prog_ack = 1'b0;
    chk("R8", "request dropped on ack", 32'(prog_req), 0);
    send_bits(10'b10_1010_1010, 10);
    chk("R5", "any frame leaves state 4", 32'(mode_state), 1);

    // R9: sealed device refuses new request
    send_bits(10'b001100, 6);
    send_bits(10'b11_1111_0000, 10);
    chk("R9", "state 3 still entered", 32'(mode_state), 3);
    chk("R9", "no request after seal", 32'(prog_req), 0);
    send_bits(10'b11_0000_0000, 10);

    // R4: undefined jump payload
    send_bits(10'b001100, 6);
    send_bits(10'b11_0011_0011, 10);
    chk("R4", "undefined jump to idle", 32'(mode_state), 1);

    // R6: read-back
    send_bits(10'b111011, 6);
    chk("R2", "read entry", 32'(mode_state), 5);
    en_pin = 1'b0; @(negedge clk);
    exp_rb = {2'b00, 8'hE1, 2'b10, 8'hA5, 2'b01, 8'h3C};
    for (int k = 0; k < 30; k++) begin
      send_bit(k[0]);
      chk("R6", $sformatf("read bit %0d", k), 32'(rb_data), 32'(exp_rb[29-k]));
    end
    chk("R6", "read ends in idle", 32'(mode_state), 1);
    chk("R6", "words unchanged", 32'(trim_words), 32'h3CA5E1);
    en_pin = 1'b1;

    // R7: timeout aborts read-back
    send_bits(10'b111011, 6);
    send_bits(10'b1010, 4);
    pulse_timeout();
    chk("R7", "timeout leaves read-back", 32'(mode_state), 1);

    // R7: timeout in programming keeps state, drops partial frame
    send_bits(10'b001100, 6);
    send_bits(10'b11111, 5);
    pulse_timeout();
    chk("R7", "timeout keeps state 2", 32'(mode_state), 2);
    send_bits(10'b00_0100_0010, 10);
    chk("R7", "frame realigned after timeout", 32'(trim_words), 32'h3CA542);
    send_bits(10'b11_1111_1111, 10);
    chk("R4", "final exit", 32'(mode_state), 1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule